// File: doc/BRIEF.md
# Floating-Point Control Register and Mode Resolver

This block keeps the floating-point control and status word for one hart. For every floating-point instruction that issues, it works out which rounding mode and which accuracy mode the instruction runs under. The word holds three things: sticky exception flags, a dynamic rounding mode, and a two-bit dynamic accuracy mode. Software reads and modifies the word through a CSR port that can write it, set bits in it or clear bits in it. Each completing arithmetic operation ORs the exceptions it raised into the flags.

The issue side gives the block the instruction's static rounding field and its instruction class. The block returns the rounding mode to use and the accuracy mode to use. It also raises a combinational illegal-instruction request in three cases:
- the static rounding field is reserved;
- the dynamic rounding mode is selected but the stored value is invalid;
- the hardware does not implement the pair of current accuracy mode and instruction class.

Which pairs are implemented is fixed by a parameter. The IEEE-compliant accuracy mode is implemented for every class. A trap is then taken elsewhere, for example so that software can emulate the missing mode.

Top module: `fp_mode_ctl`

## Requirements
- R1: After reset `csr_rdata` is 0, and with `issue_valid` low `trap_req` is 0.
- R2: Register layout: flags in bits [4:0], dynamic rounding mode in bits [7:5], accuracy mode in bits [9:8]. Bits [31:10] always read 0 and ignore writes.
- R3: `csr_op` encoding: 00 makes no change, 01 writes `csr_wdata`, 10 ORs `csr_wdata` in, 11 clears the bits set in `csr_wdata`. The result is visible on `csr_rdata` after the clock edge.
- R4: When `flag_valid` is high, `flag_in` is ORed into bits [4:0] at the clock edge. If `csr_op` is not 00 in the same cycle, the CSR result replaces the flags and `flag_in` is dropped.
- R5: For static rounding values 000 to 100, `rm_out` equals `issue_rm` and the rounding check raises no trap.
- R6: A static rounding value of 111 selects the stored dynamic rounding mode on `rm_out`.
- R7: When `issue_rm` is 111 and the stored rounding mode is 101, 110 or 111, `trap_req` is 1.
- R8: A static rounding value of 101 or 110 raises `trap_req`.
- R9: `acc_out` equals the stored accuracy mode, bits [9:8].
- R10: Pair support is read from bit `{issue_class, accuracy mode}` of `PAIR_OK`. Accuracy mode 00 is supported for every class, whatever `PAIR_OK` says. An unsupported pair raises `trap_req`. With the default `16'h053F`: class 0 supports every mode, class 1 supports modes 0 and 1, class 2 supports modes 0 and 2, and class 3 supports only mode 0.
- R11: `trap_req` is 0 whenever `issue_valid` is 0. Issuing an instruction, trapping or not, leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_op | input | 2 | CSR operation: 00 none, 01 write, 10 set, 11 clear |
| csr_wdata | input | 32 | CSR operand |
| csr_rdata | output | 32 | Current register value |
| flag_valid | input | 1 | A completing operation reports exceptions |
| flag_in | input | 5 | Exception flags to accumulate |
| issue_valid | input | 1 | A floating-point instruction is issuing |
| issue_rm | input | 3 | Static rounding field of the instruction |
| issue_class | input | CLASS_W | Instruction class |
| rm_out | output | 3 | Resolved rounding mode |
| acc_out | output | 2 | Resolved accuracy mode |
| trap_req | output | 1 | Illegal-instruction request |

## Verification
A wrong stored rounding or accuracy field shows at the ports in the same cycle as the next issue. `rm_out`, `acc_out` and `trap_req` are combinational from that state, so the bench issues right after each CSR update to expose it. A lost or corrupted flag accumulation, or a wrong priority between accumulation and a CSR operation, shows on `csr_rdata` one edge later. The bench reads the register back after every update. To show that issuing does not touch the state, the bench reads the register again after a trapping issue.

// File: rtl/fp_mode_ctl.sv
module fp_mode_ctl #(
  parameter int CLASS_W = 2,
  parameter logic [(4<<CLASS_W)-1:0] PAIR_OK = 16'h053F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         csr_op,
  input  logic [31:0]        csr_wdata,
  output logic [31:0]        csr_rdata,
  input  logic               flag_valid,
  input  logic [4:0]         flag_in,
  input  logic               issue_valid,
  input  logic [2:0]         issue_rm,
  input  logic [CLASS_W-1:0] issue_class,
  output logic [2:0]         rm_out,
  output logic [1:0]         acc_out,
  output logic               trap_req
);
  localparam int NCLASS = 1 << CLASS_W;
  localparam int PAIRS  = 4 * NCLASS;
  localparam logic [1:0] OP_NONE = 2'b00, OP_WR = 2'b01, OP_SET = 2'b10, OP_CLR = 2'b11;

  function automatic logic [PAIRS-1:0] ieee_always();
    logic [PAIRS-1:0] m;
    m = '0;
    for (int c = 0; c < NCLASS; c++) m[c*4] = 1'b1;
    return m;
  endfunction

  localparam logic [PAIRS-1:0] PAIR_EFF = PAIR_OK | ieee_always();

  logic [9:0] state_q, state_d, csr_new;
  wire  [4:0] flags_q = state_q[4:0];
  wire  [2:0] frm_q   = state_q[7:5];
  wire  [1:0] fam_q   = state_q[9:8];
  wire        unused_hi = ^csr_wdata[31:10];

  always_comb begin
    unique case (csr_op)
      OP_WR:   csr_new = csr_wdata[9:0];
      OP_SET:  csr_new = state_q | csr_wdata[9:0];
      OP_CLR:  csr_new = state_q & ~csr_wdata[9:0];
      default: csr_new = state_q;
    endcase
  end

  assign state_d = (csr_op != OP_NONE) ? csr_new
                 : {fam_q, frm_q, flags_q | (flag_valid ? flag_in : 5'd0)};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;

  assign csr_rdata = {22'd0, state_q};

  wire dyn_sel    = (issue_rm == 3'b111);
  wire static_bad = (issue_rm == 3'b101) || (issue_rm == 3'b110);
  wire dyn_bad    = dyn_sel && (frm_q > 3'b100);
  wire pair_bad   = !PAIR_EFF[{issue_class, fam_q}];

  assign rm_out   = dyn_sel ? frm_q : issue_rm;
  assign acc_out  = fam_q;
  assign trap_req = issue_valid && (static_bad || dyn_bad || pair_bad);

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_op == OP_WR) |=> (csr_rdata == {22'd0, $past(csr_wdata[9:0])}));

  assert_flags_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_op == OP_NONE) |=> ((csr_rdata[4:0] & $past(csr_rdata[4:0])) == $past(csr_rdata[4:0])));

  assert_static_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && (issue_rm == 3'b101 || issue_rm == 3'b110)) |-> trap_req);

  assert_ieee_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && acc_out == 2'b00 && issue_rm <= 3'b100) |-> !trap_req);

  assert_idle_no_trap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> !trap_req);

  assert_issue_no_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_op == OP_NONE && !flag_valid) |=> $stable(csr_rdata));
endmodule

// File: tb/test_fp_mode_ctl.sv
`timescale 1ns/1ps
module test_fp_mode_ctl;
  logic clk = 0, rst_n = 0;
  logic [1:0] csr_op = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic flag_valid = 0;
  logic [4:0] flag_in = 0;
  logic issue_valid = 0;
  logic [2:0] issue_rm = 0, rm_out;
  logic [1:0] issue_class = 0, acc_out;
  logic trap_req;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  fp_mode_ctl i_fp_mode_ctl (.clk, .rst_n, .csr_op, .csr_wdata, .csr_rdata, .flag_valid,
    .flag_in, .issue_valid, .issue_rm, .issue_class, .rm_out, .acc_out, .trap_req);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr(input logic [1:0] op, input logic [31:0] d);
    @(negedge clk); csr_op = op; csr_wdata = d;
    @(negedge clk); csr_op = 0; csr_wdata = 0;
  endtask

  task automatic issue(input logic [2:0] rm, input logic [1:0] cls);
    @(negedge clk); issue_valid = 1; issue_rm = rm; issue_class = cls; #1;
  endtask

  task automatic t_reset();
    check("R1 rdata", csr_rdata, 0);
    check("R1 trap idle", trap_req, 0);
  endtask

  task automatic t_csr_ops();
    csr(2'b01, 32'hFFFF_FFFF); check("R2 reserved zero", csr_rdata, 32'h3FF);
    csr(2'b11, 32'h0000_001F); check("R3 clear", csr_rdata, 32'h3E0);
    csr(2'b10, 32'h0000_0003); check("R3 set", csr_rdata, 32'h3E3);
    csr(2'b01, 32'h0000_0000); check("R3 write", csr_rdata, 0);
  endtask

  task automatic t_flags();
    @(negedge clk); flag_valid = 1; flag_in = 5'b00101;
    @(negedge clk); flag_in = 5'b10000;
    @(negedge clk); flag_valid = 0;
    check("R4 accumulate", csr_rdata, 32'h15);
    flag_valid = 1; flag_in = 5'b01010; csr_op = 2'b01; csr_wdata = 32'h20;
    @(negedge clk); flag_valid = 0; csr_op = 0;
    check("R4 csr priority", csr_rdata, 32'h20);
    csr(2'b01, 0);
  endtask

  task automatic t_static();
    for (int r = 0; r < 5; r++) begin
      issue(3'(r), 2'd0);
      check("R5 rm pass", rm_out, r);
      check("R5 no trap", trap_req, 0);
    end
    issue(3'b101, 0); check("R8 rm101", trap_req, 1);
    issue(3'b110, 0); check("R8 rm110", trap_req, 1);
    @(negedge clk); issue_valid = 0; issue_rm = 3'b101; #1;
    check("R11 idle no trap", trap_req, 0);
  endtask

  task automatic t_dynamic();
    csr(2'b01, 32'h60);
    issue(3'b111, 0); check("R6 dyn rm", rm_out, 3); check("R6 no trap", trap_req, 0);
    for (int f = 5; f < 8; f++) begin
      @(negedge clk); issue_valid = 0;
      csr(2'b01, 32'(f << 5));
      issue(3'b111, 0); check("R7 bad frm trap", trap_req, 1);
      issue(3'b010, 0); check("R7 static ok", trap_req, 0);
    end
    @(negedge clk); issue_valid = 0;
    csr(2'b01, 0);
  endtask

  task automatic t_accuracy();
    logic [3:0] sup [4];
    sup[0] = 4'b1111; sup[1] = 4'b0011; sup[2] = 4'b0101; sup[3] = 4'b0001;
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); issue_valid = 0;
      csr(2'b01, 32'(m << 8));
      for (int c = 0; c < 4; c++) begin
        issue(3'b000, 2'(c));
        check("R9 acc_out", acc_out, m);
        check("R10 pair trap", trap_req, !sup[c][m]);
      end
    end
    issue(3'b110, 2'd3);
    @(negedge clk); issue_valid = 0; #1;
    check("R11 state kept", csr_rdata, 32'h300);
  endtask

  initial begin
    #200_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_csr_ops();
    t_flags();
    t_static();
    t_dynamic();
    t_accuracy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule